// File: doc/BRIEF.md
# Multi-Channel Down-Count Timer Bank

This block holds a small set of independent 32-bit timers that count downwards, reached through a register bus addressed by byte offset. Each transfer is one cycle long, with separate read and write strobes. Each channel has three registers: a control word, an interval that the counter reloads from, and a read-only live count. Two registers serve all channels: a shared interrupt mask and a shared pending-flag register. The single interrupt line is high while any unmasked flag is set.

A channel takes its raw tick from one of two tick inputs, chosen by a two-bit source field. The other two codes of that field give no tick. A per-channel power-of-two prescaler divides the raw tick. Setting the load bit in the control word copies the interval into the counter on the next raw tick, and the bit then clears itself. When a running channel reaches zero it raises its pending flag. It then either reloads and continues (periodic) or stops at zero and drops its enable (one-shot). When software clears the enable bit, the channel keeps counting for two more divided ticks and only then freezes.

Top module: `mtimer_bank`

## Requirements
- R1: After reset, every register reads 0 and `irq_o` is low.
- R2: The mask register is at byte offset 0x00 and the pending register at 0x04. Channel n has its control word at 0x10+0x10·n, its interval at 0x14+0x10·n and its count at 0x18+0x10·n. The count register ignores writes. Any other offset, or a channel index at or above the channel count, reads as 0 and ignores writes. Read data appears the cycle after the read strobe and is 0 in cycles with no read.
- R3: The control word holds these fields: enable in bit 0, load in bit 1, tick source in bits 3:2, divide exponent in bits 6:4, and one-shot in bit 7. All other bits read as 0.
- R4: A load request copies the interval into the count on the next raw tick of the selected source. That tick does not also decrement. The load bit then reads 0.
- R5: While a channel is running, each divided tick lowers the count by one. The count register shows the value as it falls.
- R6: With exponent e, one divided tick occurs every 2^e raw ticks, counted from the last load.
- R7: In periodic mode (bit 7 clear), a divided tick that finds the count at 0 reloads the interval and sets the channel's pending flag. An interval of N therefore gives a period of N+1 divided ticks.
- R8: In one-shot mode (bit 7 set), a divided tick that finds the count at 0 sets the pending flag, clears the enable bit and leaves the count at 0.
- R9: After software clears the enable bit of a running channel, the channel counts exactly two more divided ticks and then holds its count.
- R10: Writing 1 to bit n of the pending register clears flag n. Writing 0 to a bit leaves that flag unchanged.
- R11: `irq_o` is high exactly when some channel has both its pending flag and its mask bit set.
- R12: Channels count, load and flag independently of each other.
- R13: Source code 0 selects `slow_tick_i` and code 1 selects `osc_tick_i`. Codes 2 and 3 give no tick, so the count stays where it is.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| slow_tick_i | input | 1 | Tick enable for source code 0 |
| osc_tick_i | input | 1 | Tick enable for source code 1 |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| addr_i | input | 8 | Byte offset of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, one cycle after the read strobe |
| irq_o | output | 1 | Combined masked interrupt |

## Verification
An error in the prescaler phase or in the load path shows up as a count off by one, read back on the first read after the faulty tick. A wrong settling counter shows as a count that keeps falling, or stops too early, within three ticks of a disable. An expiry decided one tick early or late moves the pending flag and `irq_o` by one divided tick, and in one-shot mode it also leaves the enable bit set in the control readback. Every effect is therefore visible within one tick plus one read cycle of its cause.

// File: rtl/mtb_pkg.sv
// Package: shared constants and types for the timer bank.
// Assumes 32-bit data words and byte offsets aligned to words.
package mtb_pkg;
    localparam int DATA_W     = 32;
    localparam int PRE_W      = 3;
    localparam int SETTLE_TKS = 2;

    localparam int CTL_EN     = 0;
    localparam int CTL_LOAD   = 1;
    localparam int CTL_SRC_LO = 2;
    localparam int CTL_PRE_LO = 4;
    localparam int CTL_ONE    = 7;

    localparam logic [1:0] SRC_SLOW = 2'd0;
    localparam logic [1:0] SRC_OSC  = 2'd1;

    localparam logic [3:0] OFF_A = 4'h0;
    localparam logic [3:0] OFF_B = 4'h4;
    localparam logic [3:0] OFF_C = 4'h8;

    typedef enum logic [2:0] {
        RK_NONE,
        RK_MASK,
        RK_PEND,
        RK_CTL,
        RK_INTV,
        RK_CNT
    } reg_kind_e;
endpackage

// File: rtl/mtb_decode.sv
// Address decoder: maps a byte offset to a register kind and a channel index.
// Assumes block 0 holds the shared registers and block k+1 holds channel k.
module mtb_decode
    import mtb_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int NCH    = 2,
    localparam int CH_W  = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic [ADDR_W-1:0] addr_i,
    output reg_kind_e         kind_o,
    output logic [CH_W-1:0]   ch_o
);
    localparam int BLK_W = ADDR_W - 4;
    localparam logic [BLK_W-1:0] NCH_B = BLK_W'(NCH);

    logic [BLK_W-1:0] blk;
    logic [3:0]       off;

    assign blk = addr_i[ADDR_W-1:4];
    assign off = addr_i[3:0];

    // Classify the offset into one register kind.
    always_comb begin
        kind_o = RK_NONE;
        ch_o   = CH_W'(blk - BLK_W'(1));
        if (blk == '0) begin
            if (off == OFF_A)      kind_o = RK_MASK;
            else if (off == OFF_B) kind_o = RK_PEND;
        end else if (blk <= NCH_B) begin
            if (off == OFF_A)      kind_o = RK_CTL;
            else if (off == OFF_B) kind_o = RK_INTV;
            else if (off == OFF_C) kind_o = RK_CNT;
        end
    end
endmodule

// File: rtl/mtb_prescale.sv
// Prescaler: picks the raw tick by source code and divides it by 2^exp.
// Assumes ticks are single-cycle enables; the phase restarts on clr_i.
module mtb_prescale
    import mtb_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       src_i,
    input  logic [PRE_W-1:0] exp_i,
    input  logic             slow_tick_i,
    input  logic             osc_tick_i,
    input  logic             run_i,
    input  logic             clr_i,
    output logic             stick_o,
    output logic             ptick_o
);
    localparam int DIV_W = (1 << PRE_W) - 1;

    logic [DIV_W-1:0] phase_q;
    logic [DIV_W-1:0] mask;

    // Select the raw tick; codes other than the two sources give none.
    always_comb begin
        case (src_i)
            SRC_SLOW: stick_o = slow_tick_i;
            SRC_OSC:  stick_o = osc_tick_i;
            default:  stick_o = 1'b0;
        endcase
    end

    assign mask    = (DIV_W'(1) << exp_i) - DIV_W'(1);
    assign ptick_o = run_i && stick_o && ((phase_q & mask) == mask);

    // Advance the divide phase on each raw tick while the channel runs.
    always_ff @(posedge clk) begin
        if (!rst_n)                phase_q <= '0;
        else if (clr_i)            phase_q <= '0;
        else if (run_i && stick_o) phase_q <= phase_q + DIV_W'(1);
    end
endmodule

// File: rtl/mtb_channel.sv
// Timer channel: control word, interval, down counter, load and settle logic.
// Assumes the writes it sees are already decoded to this channel.
module mtb_channel
    import mtb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slow_tick_i,
    input  logic              osc_tick_i,
    input  logic              ctl_we_i,
    input  logic              intv_we_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] ctl_o,
    output logic [DATA_W-1:0] intv_o,
    output logic [DATA_W-1:0] cnt_o,
    output logic              en_o,
    output logic              oneshot_o,
    output logic              load_o,
    output logic              stick_o,
    output logic              expire_o
);
    localparam int SET_W = $clog2(SETTLE_TKS + 1);

    logic             en_q, load_q, one_q;
    logic [1:0]       src_q;
    logic [PRE_W-1:0] exp_q;
    logic [DATA_W-1:0] intv_q, cnt_q;
    logic [SET_W-1:0] settle_q;
    logic             run, do_load, ptick, stick;

    assign run      = en_q || (settle_q != '0);
    assign do_load  = load_q && stick;
    assign expire_o = !do_load && ptick && (cnt_q == '0);

    mtb_prescale u_pre (
        .clk         (clk),
        .rst_n       (rst_n),
        .src_i       (src_q),
        .exp_i       (exp_q),
        .slow_tick_i (slow_tick_i),
        .osc_tick_i  (osc_tick_i),
        .run_i       (run),
        .clr_i       (do_load),
        .stick_o     (stick),
        .ptick_o     (ptick)
    );

    // Control fields: software writes, hardware clears load and one-shot enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            load_q <= 1'b0;
            one_q  <= 1'b0;
            src_q  <= '0;
            exp_q  <= '0;
        end else if (ctl_we_i) begin
            en_q   <= wdata_i[CTL_EN];
            load_q <= wdata_i[CTL_LOAD];
            one_q  <= wdata_i[CTL_ONE];
            src_q  <= wdata_i[CTL_SRC_LO +: 2];
            exp_q  <= wdata_i[CTL_PRE_LO +: PRE_W];
        end else begin
            if (do_load)            load_q <= 1'b0;
            if (expire_o && one_q)  en_q   <= 1'b0;
        end
    end

    // Settle counter: arm on a software disable, drain on divided ticks.
    always_ff @(posedge clk) begin
        if (!rst_n)                               settle_q <= '0;
        else if (ctl_we_i && wdata_i[CTL_EN])     settle_q <= '0;
        else if (ctl_we_i && en_q)                settle_q <= SET_W'(SETTLE_TKS);
        else if (expire_o && one_q)               settle_q <= '0;
        else if (ptick && !en_q && settle_q != '0) settle_q <= settle_q - SET_W'(1);
    end

    // Interval register: written by software only.
    always_ff @(posedge clk) begin
        if (!rst_n)         intv_q <= '0;
        else if (intv_we_i) intv_q <= wdata_i;
    end

    // Counter: load, decrement, reload or hold at zero on expiry.
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt_q <= '0;
        else if (do_load) cnt_q <= intv_q;
        else if (ptick) begin
            if (cnt_q != '0) cnt_q <= cnt_q - DATA_W'(1);
            else if (!one_q) cnt_q <= intv_q;
        end
    end

    assign ctl_o     = {{(DATA_W-8){1'b0}}, one_q, exp_q, src_q, load_q, en_q};
    assign intv_o    = intv_q;
    assign cnt_o     = cnt_q;
    assign en_o      = en_q;
    assign oneshot_o = one_q;
    assign load_o    = load_q;
    assign stick_o   = stick;
endmodule

// File: rtl/mtimer_bank.sv
// Timer bank top: bus decode, shared mask and pending registers, channels.
// Assumes single-cycle strobes; read data is registered and zero when idle.
module mtimer_bank
    import mtb_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int NCH    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slow_tick_i,
    input  logic              osc_tick_i,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              irq_o
);
    localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1;

    reg_kind_e                  kind;
    logic [CH_W-1:0]            ch;
    logic [NCH-1:0]             mask_q, pend_q, pend_clr;
    logic [NCH-1:0][DATA_W-1:0] ctl_w, intv_w, cnt_w;
    logic [NCH-1:0]             en_w, one_w, load_w, stick_w, expire_w;
    logic [NCH-1:0]             ctl_we, intv_we;
    logic [DATA_W-1:0]          rd_val, rdata_q;

    mtb_decode #(.ADDR_W(ADDR_W), .NCH(NCH)) u_dec (
        .addr_i (addr_i),
        .kind_o (kind),
        .ch_o   (ch)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        assign ctl_we[i]  = wr_en_i && (kind == RK_CTL)  && (ch == CH_W'(i));
        assign intv_we[i] = wr_en_i && (kind == RK_INTV) && (ch == CH_W'(i));

        mtb_channel u_ch (
            .clk         (clk),
            .rst_n       (rst_n),
            .slow_tick_i (slow_tick_i),
            .osc_tick_i  (osc_tick_i),
            .ctl_we_i    (ctl_we[i]),
            .intv_we_i   (intv_we[i]),
            .wdata_i     (wdata_i),
            .ctl_o       (ctl_w[i]),
            .intv_o      (intv_w[i]),
            .cnt_o       (cnt_w[i]),
            .en_o        (en_w[i]),
            .oneshot_o   (one_w[i]),
            .load_o      (load_w[i]),
            .stick_o     (stick_w[i]),
            .expire_o    (expire_w[i])
        );
    end

    assign pend_clr = (wr_en_i && kind == RK_PEND) ? wdata_i[NCH-1:0] : '0;

    // Shared registers: mask written directly, pending flags set by expiry, cleared by write-one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
            pend_q <= '0;
        end else begin
            if (wr_en_i && kind == RK_MASK) mask_q <= wdata_i[NCH-1:0];
            pend_q <= (pend_q & ~pend_clr) | expire_w;
        end
    end

    // Read multiplexer over all mapped registers.
    always_comb begin
        case (kind)
            RK_MASK: rd_val = DATA_W'(mask_q);
            RK_PEND: rd_val = DATA_W'(pend_q);
            RK_CTL:  rd_val = ctl_w[ch];
            RK_INTV: rd_val = intv_w[ch];
            RK_CNT:  rd_val = cnt_w[ch];
            default: rd_val = '0;
        endcase
    end

    // Read data register: captures on a read strobe, otherwise zero.
    always_ff @(posedge clk) begin
        if (!rst_n)       rdata_q <= '0;
        else if (rd_en_i) rdata_q <= rd_val;
        else              rdata_q <= '0;
    end

    assign rdata_o = rdata_q;
    assign irq_o   = |(pend_q & mask_q);
endmodule

// File: rtl/mtimer_bank_chk.sv
// Checker for the timer bank, bound to the top module.
// Assumes the internal vectors exposed by the top module are connected by name.
module mtimer_bank_chk #(
    parameter int NCH = 2
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   wr_en_i,
    input logic                   rd_en_i,
    input logic [31:0]            rdata_o,
    input logic                   irq_o,
    input logic [NCH-1:0]         mask_q,
    input logic [NCH-1:0]         pend_q,
    input logic [NCH-1:0][31:0]   cnt_w,
    input logic [NCH-1:0][31:0]   intv_w,
    input logic [NCH-1:0]         en_w,
    input logic [NCH-1:0]         one_w,
    input logic [NCH-1:0]         load_w,
    input logic [NCH-1:0]         stick_w,
    input logic [NCH-1:0]         expire_w
);
    // R2: idle cycles return zero read data
    a_r2_idle_rdata: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en_i |=> rdata_o == 32'd0);

    // R11: no mask bit set means no interrupt
    a_r11_masked: assert property (@(posedge clk) disable iff (!rst_n)
        mask_q == '0 |-> !irq_o);

    for (genvar i = 0; i < NCH; i++) begin : g_c
        // R4: a load clears its own request
        a_r4_load_clears: assert property (@(posedge clk) disable iff (!rst_n)
            load_w[i] && stick_w[i] && !wr_en_i |=> !load_w[i]);

        // R5: the count only steps down by one or takes the interval
        a_r5_count_step: assert property (@(posedge clk) disable iff (!rst_n)
            !$stable(cnt_w[i]) |->
                (cnt_w[i] == $past(cnt_w[i]) - 32'd1) || (cnt_w[i] == $past(intv_w[i])));

        // R7: expiry raises the pending flag
        a_r7_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
            expire_w[i] |=> pend_q[i]);

        // R8: one-shot expiry stops the channel at zero
        a_r8_oneshot_stop: assert property (@(posedge clk) disable iff (!rst_n)
            expire_w[i] && one_w[i] && !wr_en_i |=> !en_w[i] && cnt_w[i] == 32'd0);
    end
endmodule

bind mtimer_bank mtimer_bank_chk #(.NCH(NCH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en_i  (wr_en_i),
    .rd_en_i  (rd_en_i),
    .rdata_o  (rdata_o),
    .irq_o    (irq_o),
    .mask_q   (mask_q),
    .pend_q   (pend_q),
    .cnt_w    (cnt_w),
    .intv_w   (intv_w),
    .en_w     (en_w),
    .one_w    (one_w),
    .load_w   (load_w),
    .stick_w  (stick_w),
    .expire_w (expire_w)
);

// File: tb/mtimer_bank_tb.sv
// Scoreboard bench: read tasks queue expected words, a monitor compares them.
module mtimer_bank_tb;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        slow_tick = 1'b0, osc_tick = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #(CLK_P/2) clk = ~clk;

    mtimer_bank u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .slow_tick_i (slow_tick),
        .osc_tick_i  (osc_tick),
        .wr_en_i     (wr_en),
        .rd_en_i     (rd_en),
        .addr_i      (addr),
        .wdata_i     (wdata),
        .rdata_o     (rdata),
        .irq_o       (irq)
    );

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] e, input string t);
        @(negedge clk); rd_en = 1'b1; addr = a;
        exp_q.push_back(e); tag_q.push_back(t);
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic tick(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk); osc_tick = 1'b1;
            @(negedge clk); osc_tick = 1'b0;
        end
    endtask

    task automatic slow(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk); slow_tick = 1'b1;
            @(negedge clk); slow_tick = 1'b0;
        end
    endtask

    task automatic chk_irq(input logic e, input string t);
        n_chk++;
        if (irq !== e) begin
            n_bad++;
            $display("FAIL %s irq actual %0b expected %0b", t, irq, e);
        end
    endtask

    // Monitor: pop one expected word per read and compare with the data.
    always @(posedge clk) begin
        if (rd_en) begin
            #1;
            if (exp_q.size() == 0) begin
                n_chk++; n_bad++;
                $display("FAIL R2 unexpected read actual %h expected none", rdata);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front(); t = tag_q.pop_front();
                n_chk++;
                if (rdata !== e) begin
                    n_bad++;
                    $display("FAIL %s actual %h expected %h", t, rdata, e);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        chk_irq(1'b0, "R1 reset irq");
        rd(8'h00, 32'h0, "R1 mask");
        rd(8'h04, 32'h0, "R1 pend");
        rd(8'h10, 32'h0, "R1 ctl0");
        rd(8'h24, 32'h0, "R1 intv1");
        rd(8'h28, 32'h0, "R1 cnt1");

        // R2: map, read-only count, unmapped offsets
        wr(8'h0C, 32'hFFFF_FFFF);
        rd(8'h0C, 32'h0, "R2 unmapped 0x0C");
        rd(8'h3C, 32'h0, "R2 unmapped 0x3C");
        wr(8'h30, 32'h0000_00FF);
        rd(8'h30, 32'h0, "R2 channel beyond count");
        rd(8'h02, 32'h0, "R2 misaligned");
        wr(8'h14, 32'd5);
        rd(8'h14, 32'd5, "R2 intv0 readback");
        wr(8'h18, 32'h1234);
        rd(8'h18, 32'h0, "R2 count ignores write");
        rd(8'h00, 32'h0, "R2 mask untouched by unmapped write");

        // R3: control layout, upper bits read zero
        wr(8'h10, 32'hFFFF_FF7C);
        rd(8'h10, 32'h0000_007C, "R3 ctl fields");

        // R4 R5 R7: periodic interval 3 on the oscillator tick
        wr(8'h14, 32'd3);
        wr(8'h10, 32'h07);
        rd(8'h10, 32'h07, "R4 load pending");
        tick(1);
        rd(8'h18, 32'd3, "R4 load on tick");
        rd(8'h10, 32'h05, "R4 load bit self-clears");
        tick(1);
        rd(8'h18, 32'd2, "R5 decrement");
        tick(2);
        rd(8'h18, 32'd0, "R5 reaches zero");
        rd(8'h04, 32'h0, "R7 no flag before expiry");
        tick(1);
        rd(8'h18, 32'd3, "R7 periodic reload");
        rd(8'h04, 32'h1, "R7 flag set");
        chk_irq(1'b0, "R11 masked flag");
        wr(8'h00, 32'h1);
        chk_irq(1'b1, "R11 unmasked flag");
        wr(8'h04, 32'h1);
        rd(8'h04, 32'h0, "R10 write-one clears");
        chk_irq(1'b0, "R11 after clear");
        tick(4);
        rd(8'h04, 32'h1, "R7 period N+1");
        wr(8'h04, 32'h2);
        rd(8'h04, 32'h1, "R10 zero bit keeps flag");
        wr(8'h04, 32'h1);

        // R13: source codes
        wr(8'h10, 32'h09);
        tick(3);
        rd(8'h18, 32'd3, "R13 code 2 gives no tick");
        wr(8'h10, 32'h01);
        tick(2);
        rd(8'h18, 32'd3, "R13 code 0 ignores oscillator");
        slow(1);
        rd(8'h18, 32'd2, "R13 code 0 follows slow tick");

        // R6: divide by 4
        wr(8'h14, 32'd2);
        wr(8'h10, 32'h27);
        tick(1);
        rd(8'h18, 32'd2, "R6 loaded");
        tick(3);
        rd(8'h18, 32'd2, "R6 holds for 3 raw ticks");
        tick(1);
        rd(8'h18, 32'd1, "R6 fourth raw tick");
        tick(3);
        rd(8'h18, 32'd1, "R6 second period holds");
        tick(1);
        rd(8'h18, 32'd0, "R6 second divided tick");

        // R8: one-shot
        wr(8'h14, 32'd1);
        wr(8'h10, 32'h87);
        tick(2);
        rd(8'h18, 32'd0, "R8 counted to zero");
        rd(8'h04, 32'h0, "R8 no flag yet");
        tick(1);
        rd(8'h04, 32'h1, "R8 flag set");
        rd(8'h10, 32'h84, "R8 enable cleared");
        chk_irq(1'b1, "R11 one-shot flag");
        tick(3);
        rd(8'h18, 32'd0, "R8 holds at zero");
        wr(8'h04, 32'h1);

        // R9: disable settles after two divided ticks
        wr(8'h14, 32'd10);
        wr(8'h10, 32'h07);
        tick(3);
        rd(8'h18, 32'd8, "R9 running");
        wr(8'h10, 32'h04);
        tick(1);
        rd(8'h18, 32'd7, "R9 first settle tick");
        tick(1);
        rd(8'h18, 32'd6, "R9 second settle tick");
        tick(3);
        rd(8'h18, 32'd6, "R9 frozen");
        rd(8'h10, 32'h04, "R9 ctl after disable");

        // R12: channel 1 alone
        wr(8'h24, 32'd1);
        wr(8'h20, 32'h07);
        tick(1);
        rd(8'h28, 32'd1, "R12 ch1 loaded");
        tick(2);
        rd(8'h04, 32'h2, "R12 ch1 flag only");
        rd(8'h18, 32'd6, "R12 ch0 untouched");
        chk_irq(1'b0, "R11 ch1 masked");
        wr(8'h00, 32'h3);
        chk_irq(1'b1, "R11 ch1 unmasked");
        wr(8'h04, 32'h2);
        chk_irq(1'b0, "R10 ch1 cleared");

        repeat (3) @(negedge clk);
        n_chk++;
        if (exp_q.size() != 0) begin
            n_bad++;
            $display("FAIL R2 reads outstanding actual %0d expected 0", exp_q.size());
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule